// File: doc/BRIEF.md
# Set-Associative LRU Tag Profiler

This block models the tag side of a set-associative cache and counts its misses. It holds no data. A client presents one memory reference at a time as a start address and a byte count. The block looks the reference up in a tag array of `SETS` sets by `WAYS` ways. Each set is kept in recency order, with way 0 as the most recently used entry. The block returns a one-cycle response that says hit, miss or error, and it adds every missed reference to a saturating counter. Every miss allocates, whether the reference is a read or a write: the missing tag is always installed.

A reference whose last byte falls in the next line is looked up in both lines but counts as one access. It reports one miss if either line misses, and one hit only if both hit. A reference whose end lands in any set other than the same set or the next set (modulo the set count) is rejected as an error.

The sequencer runs four named states:

- **IDLE**: accepts a request (`req_valid` and `req_ready`). → LOOKUP1.
- **LOOKUP1**: looks up the first line and reorders its set, or flags an error without touching the array. → LOOKUP2 when the reference straddles; otherwise → DONE.
- **LOOKUP2**: looks up the second line and reorders its set. → DONE.
- **DONE**: drives the response pulse and bumps the counter on a miss. → IDLE.

With `WAYS = 1` the same logic behaves as a direct-mapped cache.

Top module: `lru_tag_profiler`

## Requirements
- R1: `SETS = CACHE_BYTES / LINE_BYTES / WAYS`. With `OFF_W = log2(LINE_BYTES)` and `IDX_W = log2(SETS)`, the set index is address bits `[OFF_W+IDX_W-1:OFF_W]` and the tag is every address bit above them; no hashing is applied (defaults: 16 sets, index = bits 7:4, tag = bits 31:8).
- R2: After reset every stored tag is zero, `miss_count` is zero, `req_ready` is 1 and `rsp_valid` is 0, so a first reference whose tag is zero hits.
- R3: A hit at way i moves that tag to way 0 and shifts ways 0 to i−1 down by one; a hit at way 0 leaves the set unchanged. When several ways hold the same tag, the lowest-numbered one counts as the match.
- R4: A miss shifts every way of the set down by one, which drops way `WAYS-1`, and writes the new tag into way 0.
- R5: `req_ready` is 1 only in IDLE. `rsp_valid` is a single-cycle pulse. It comes 2 cycles after the accepting edge for a single-line or error reference, and 3 cycles after it for a straddling reference.
- R6: The second line is taken from the end address `addr + size - 1`, where a size of 0 is treated as 1. The reference straddles when the end set equals the start set + 1 modulo `SETS`, so the last set wraps to set 0. Both lines are looked up and reordered, first line first, and `rsp_miss` is 1 if either line missed.
- R7: When the end set is neither the start set nor the next set, the response carries `rsp_error` = 1 and `rsp_miss` = 0. The tag array and `miss_count` are left unchanged.
- R8: `miss_count` (`CNT_W` bits, default 64) increases by one for each missed response, and only once for a straddling reference. The new value is visible in the cycle after `rsp_valid`. The counter holds at all ones once it reaches that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | SIZE_W | Byte count of the reference (0 is treated as 1) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_miss | output | 1 | Reference missed (valid with rsp_valid) |
| rsp_error | output | 1 | Reference spans an illegal set pair (valid with rsp_valid) |
| miss_count | output | CNT_W | Saturating count of missed references |

## Verification
On every cycle, the embedded assertions check the following:

- the handshake and response pulse shape;
- that an error response never reports a miss and never moves the counter;
- the counter's increment and saturation;
- that each array update leaves the looked-up tag in way 0.

Only the bench's scenarios can show the full recency order. A behavioural queue model exposes it through later hits and misses: LRU eviction after a hit reorders a set, straddles that wrap from the last set to set 0, the combined hit/miss rule for two lines, and the treatment of zero-size references.

// File: rtl/lru_prof_pkg.sv
package lru_prof_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP1,
        ST_LOOKUP2,
        ST_DONE
    } prof_state_e;

endpackage

// File: rtl/lru_tag_store.sv
module lru_tag_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int IDX_W = 4,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    input  logic             upd_en,
    output logic             hit
);
    localparam int POS_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [TAG_W-1:0] tag_mem [SETS][WAYS];
    logic [WAYS-1:0]  match;
    logic [POS_W-1:0] pos;

    // per-way comparators
    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = (tag_mem[look_idx][w] == look_tag);
        end
    endgenerate

    // lowest matching way wins; a miss shifts the whole set
    always_comb begin
        hit = |match;
        pos = POS_W'(WAYS - 1);
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) pos = POS_W'(w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    tag_mem[s][w] <= '0;
        end else if (upd_en) begin
            tag_mem[look_idx][0] <= look_tag;
            for (int w = 1; w < WAYS; w++) begin
                if (w <= int'(pos))
                    tag_mem[look_idx][w] <= tag_mem[look_idx][w-1];
            end
        end
    end

    AST_MRU_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> tag_mem[$past(look_idx)][0] == $past(look_tag)); // R4

endmodule

// File: rtl/lru_miss_ctr.sv
module lru_miss_ctr #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (bump && count != TOP)
            count <= count + 1'b1;
    end

    AST_CNT_HOLDS_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) |=> (count == TOP)); // R8

    AST_CNT_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && count != TOP) |=> (count == $past(count) + 1'b1)); // R8

    AST_CNT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(count)); // R8

endmodule

// File: rtl/lru_tag_profiler.sv
module lru_tag_profiler
    import lru_prof_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CACHE_BYTES = 1024,
    parameter int LINE_BYTES  = 16,
    parameter int WAYS        = 4,
    parameter int SIZE_W      = 5,
    parameter int CNT_W       = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    output logic              rsp_valid,
    output logic              rsp_miss,
    output logic              rsp_error,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int SETS   = CACHE_BYTES / LINE_BYTES / WAYS;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = ADDR_W - OFF_W;

    prof_state_e state, state_nx;

    logic [LINE_W-1:0] line1_q, line2_q;
    logic              miss_q, err_q;

    logic [SIZE_W-1:0] span;
    logic [LINE_W-1:0] end_line;
    logic [OFF_W-1:0]  end_off_unused;

    logic [IDX_W-1:0]  idx1, idx2, idx1_next, look_idx;
    logic [TAG_W-1:0]  tag1, tag2, look_tag;
    logic              straddle, bad_span, upd_en, hit, bump;

    // end address of the reference, size 0 counts as one byte
    assign span = (req_size == '0) ? '0 : req_size - 1'b1;
    assign {end_line, end_off_unused} = req_addr + {{(ADDR_W-SIZE_W){1'b0}}, span};

    assign idx1      = line1_q[IDX_W-1:0];
    assign idx2      = line2_q[IDX_W-1:0];
    assign tag1      = line1_q[LINE_W-1:IDX_W];
    assign tag2      = line2_q[LINE_W-1:IDX_W];
    assign idx1_next = idx1 + 1'b1;
    assign straddle  = (idx1 != idx2) && (idx2 == idx1_next);
    assign bad_span  = (idx1 != idx2) && !straddle;

    assign look_idx  = (state == ST_LOOKUP2) ? idx2 : idx1;
    assign look_tag  = (state == ST_LOOKUP2) ? tag2 : tag1;
    assign upd_en    = ((state == ST_LOOKUP1) && !bad_span) || (state == ST_LOOKUP2);
    assign bump      = (state == ST_DONE) && miss_q && !err_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nx = ST_LOOKUP1;
            ST_LOOKUP1: state_nx = straddle ? ST_LOOKUP2 : ST_DONE;
            ST_LOOKUP2: state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_DONE);
        rsp_miss  = miss_q && !err_q;
        rsp_error = err_q;
    end

    // request capture and lookup result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line1_q <= '0;
            line2_q <= '0;
            miss_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    line1_q <= req_addr[ADDR_W-1:OFF_W];
                    line2_q <= end_line;
                    miss_q  <= 1'b0;
                    err_q   <= 1'b0;
                end
                ST_LOOKUP1: begin
                    if (bad_span) err_q  <= 1'b1;
                    else          miss_q <= !hit;
                end
                ST_LOOKUP2: miss_q <= miss_q | !hit;
                ST_DONE:    ;
                default:    ;
            endcase
        end
    end

    lru_tag_store #(
        .SETS (SETS),
        .WAYS (WAYS),
        .IDX_W(IDX_W),
        .TAG_W(TAG_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .look_idx(look_idx),
        .look_tag(look_tag),
        .upd_en  (upd_en),
        .hit     (hit)
    );

    lru_miss_ctr #(
        .CNT_W(CNT_W)
    ) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .bump (bump),
        .count(miss_count)
    );

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R5

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R5

    AST_ERR_NOT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_error) |-> !rsp_miss); // R7

    AST_ERR_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_error) |=> $stable(miss_count)); // R7

    AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP1 && bad_span) |-> !upd_en); // R7

endmodule

// File: tb/lru_tag_profiler_test.sv
module lru_tag_profiler_test;
    localparam int ADDR_W = 32;
    localparam int SETS   = 16;
    localparam int WAYS   = 4;
    localparam int SIZE_W = 5;
    localparam int CNT_W  = 4;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [SIZE_W-1:0] req_size = '0;
    logic              rsp_valid, rsp_miss, rsp_error;
    logic [CNT_W-1:0]  miss_count;

    int checks = 0;
    int fails  = 0;
    int mcnt   = 0;
    int unsigned mq [SETS][$];

    always #2 clk = ~clk;

    lru_tag_profiler #(
        .ADDR_W(ADDR_W), .CACHE_BYTES(1024), .LINE_BYTES(16),
        .WAYS(WAYS), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
        .rsp_miss(rsp_miss), .rsp_error(rsp_error), .miss_count(miss_count)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural recency list per set, front = most recent
    function automatic bit model_line(int s, int unsigned t);
        int at = -1;
        foreach (mq[s][i]) if (at < 0 && mq[s][i] == t) at = i;
        if (at >= 0) begin
            mq[s].delete(at);
            mq[s].push_front(t);
            return 1'b0;
        end
        mq[s].push_front(t);
        void'(mq[s].pop_back());
        return 1'b1;
    endfunction

    task automatic do_ref(string req, logic [31:0] a, int sz);
        logic [31:0] last;
        int s1, s2, lat;
        bit em, er, m1, m2;
        last = a + ((sz == 0) ? 32'd0 : 32'(sz - 1));
        s1 = int'((a >> 4) & 32'hF);
        s2 = int'((last >> 4) & 32'hF);
        er = 1'b0; em = 1'b0; lat = 1;
        if (s1 == s2) begin
            em = model_line(s1, a >> 8);
        end else if (s2 == (s1 + 1) % SETS) begin
            m1 = model_line(s1, a >> 8);
            m2 = model_line(s2, last >> 8);
            em = m1 | m2;
            lat = 2;
        end else begin
            er = 1'b1;
        end
        chk("R5", "ready before request", req_ready, 1);
        req_addr = a; req_size = SIZE_W'(sz); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5", "no early response", rsp_valid, 0);
        chk("R5", "busy after accept", req_ready, 0);
        if (lat == 2) begin
            @(negedge clk);
            chk("R6", "straddle takes extra cycle", rsp_valid, 0);
        end
        @(negedge clk);
        chk("R5", "response strobe", rsp_valid, 1);
        chk(req, "rsp_miss", rsp_miss, em);
        chk(er ? "R7" : req, "rsp_error", rsp_error, er);
        chk("R8", "count not yet updated", miss_count, mcnt);
        if (em && !er && mcnt < CMAX) mcnt++;
        @(negedge clk);
        chk("R5", "strobe is one cycle", rsp_valid, 0);
        chk("R5", "ready again", req_ready, 1);
        chk(er ? "R7" : "R8", "miss_count", miss_count, mcnt);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] x;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) mq[s].push_back(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "ready after reset", req_ready, 1);
        chk("R2", "no response after reset", rsp_valid, 0);
        chk("R2", "count after reset", miss_count, 0);

        do_ref("R2", 32'h0000_0004, 4);      // zero tag hits after reset
        do_ref("R4", 32'h0000_0100, 4);      // fill set 0 (R1: bits 7:4 index)
        do_ref("R4", 32'h0000_0200, 4);
        do_ref("R4", 32'h0000_0300, 4);
        do_ref("R4", 32'h0000_0400, 4);
        do_ref("R3", 32'h0000_0100, 2);      // LRU entry hit moves to front
        do_ref("R3", 32'h0000_0104, 1);      // MRU hit
        do_ref("R4", 32'h0000_0500, 4);      // evicts tag 2
        do_ref("R4", 32'h0000_0200, 4);      // tag 2 must miss now
        do_ref("R3", 32'h0000_0108, 4);      // tag 1 survived
        do_ref("R1", 32'h0000_0110, 4);      // set 1 tag 1: miss
        do_ref("R1", 32'h0000_1110, 4);      // same set, other tag
        do_ref("R6", 32'h0000_012C, 8);      // set 2 -> set 3
        do_ref("R6", 32'h0000_012C, 8);      // now both hit
        do_ref("R6", 32'h0000_00FC, 8);      // set 15 wraps to set 0
        do_ref("R6", 32'h0000_03FA, 0);      // size 0 treated as 1
        do_ref("R7", 32'h0000_000F, 31);     // spans three lines
        do_ref("R7", 32'h0000_0100, 4);      // array untouched by error
        x = 32'h1234_5679;
        for (int n = 0; n < 150; n++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            do_ref("R3", x & 32'h0000_0FFF, int'((x >> 16) % 20));
        end
        chk("R8", "saturated count", miss_count, CMAX);
        do_ref("R8", 32'h0000_0F00, 4);
        chk("R8", "count held at top", miss_count, CMAX);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule